// File: doc/BRIEF.md
# Operand Load and Readback Port

This block moves field-element operands between an external word-wide port and the bank of operand registers that feed the arithmetic core. Each external word crosses under a four-phase request/acknowledge handshake, so the sender may run at any rate. The external word width is a parameter and is independent of the element width. An element of `ELEM_W` bits occupies `WORDS = ceil(ELEM_W/DATA_W)` words. The word with the lowest-order bits always comes first, and bits above `ELEM_W-1` in the top word are padding.

Two access modes share the same registers. In serial mode a whole element streams through a shift buffer, one word per handshake, and the target register is written only when the final word arrives. In addressed mode every handshake names a register and a word offset, which gives random access to single words. The full contents of every register are always visible on `opnd_o` for the core.

Top module: `opio_top`

## Requirements
- R1: While `rst_ni` is low and just after reset, `ack_o`, `err_o`, `rdata_o` and every register on `opnd_o` are zero.
- R2: `ack_o` rises one clock after `req_i` is seen high with `ack_o` low. It stays high while `req_i` stays high and falls one clock after `req_i` is seen low. Exactly one word is transferred per handshake.
- R3: With `mode_i`=0 (serial) and `we_i`=1 (write), `WORDS` handshakes load register `idx_i`, lowest word first. Bits of the final word above `ELEM_W-1` are dropped.
- R4: During a serial write the target register keeps its old value until the final word's handshake.
- R5: With `mode_i`=0 and `we_i`=0 (read), `WORDS` handshakes return register `idx_i` on `rdata_o`, lowest word first, with zeros above `ELEM_W-1` in the final word. `rdata_o` is valid while `ack_o` is high.
- R6: With `mode_i`=1 (addressed) and `we_i`=1, word `off_i` of register `idx_i` takes `wdata_i`, and no other bit of any register changes. Padding bits are dropped.
- R7: With `mode_i`=1 and `we_i`=0, `rdata_o` returns word `off_i` of register `idx_i`, with zeros above `ELEM_W-1`.
- R8: An addressed transfer with `off_i` >= `WORDS` changes no register, returns zero on a read, and sets `err_o`. A valid addressed transfer clears `err_o`. Serial transfers leave `err_o` unchanged.
- R9: `mode_i`, `idx_i` and `we_i` are sampled only on the first word of a serial element. While a serial element is incomplete, a request is handled as serial on the latched register and direction, whatever those inputs show.
- R10: Asserting `rst_ni` in the middle of a serial element discards it. The next serial element starts again at its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Word request from the sender |
| we_i | input | 1 | 1 = write, 0 = read |
| mode_i | input | 1 | 0 = serial, 1 = addressed |
| idx_i | input | IDX_W | Operand register index |
| off_i | input | OFF_W | Word offset (addressed mode) |
| wdata_i | input | DATA_W | Write word |
| ack_o | output | 1 | Word acknowledge |
| rdata_o | output | DATA_W | Read word, valid while ack_o is high |
| err_o | output | 1 | Last addressed offset was out of range |
| opnd_o | output | NUM_REGS*ELEM_W | All operand registers, register r at bits [r*ELEM_W +: ELEM_W] |

## Verification
The assertions assume that the sender obeys the four-phase protocol. This means it holds `req_i` high until `ack_o` rises, keeps it low until `ack_o` falls, and keeps `we_i`, `mode_i`, `idx_i`, `off_i` and `wdata_i` steady from the rise of `req_i` until `ack_o` answers. Under that rule the properties state that operand contents, the error flag and the read word move only at an acknowledge edge. The bench drives every input from one task on the falling clock edge and waits for each acknowledge phase before the next change, so it never leaves that protocol. The one exception is the deliberate reset in the middle of a serial element.

// File: rtl/opio_pkg.sv
package opio_pkg;
  typedef enum logic {
    MODE_SER = 1'b0,
    MODE_ADR = 1'b1
  } opio_mode_e;

  function automatic int words_of(input int elem_w, input int data_w);
    return (elem_w + data_w - 1) / data_w;
  endfunction
endpackage

// File: rtl/opio_hs.sv
module opio_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic ack_o,
  output logic fire_o
);
  logic ack_q;

  assign fire_o = req_i & ~ack_q;
  assign ack_o  = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ack_q <= 1'b0;
    else if (req_i & ~ack_q) ack_q <= 1'b1;
    else if (~req_i & ack_q) ack_q <= 1'b0;
  end
endmodule

// File: rtl/opio_shift.sv
module opio_shift #(
  parameter int ELEM_W = 163,
  parameter int DATA_W = 32,
  parameter int WORDS  = 6,
  localparam int BUF_W = WORDS * DATA_W,
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              we_i,
  input  logic [ELEM_W-1:0] src_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              we_eff_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              commit_o,
  output logic [ELEM_W-1:0] commit_data_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic [BUF_W-1:0] buf_q, src_ext, rd_base, wr_next;
  logic             last;

  assign src_ext  = BUF_W'(src_i);
  assign busy_o   = cnt_q != '0;
  assign we_eff_o = busy_o ? dir_q : we_i;
  assign last     = cnt_q == CNT_W'(WORDS - 1);
  assign rd_base  = busy_o ? buf_q : src_ext;
  assign rdata_o  = rd_base[DATA_W-1:0];
  assign wr_next  = {wdata_i, buf_q[BUF_W-1:DATA_W]};

  assign commit_o      = fire_i & we_eff_o & last;
  assign commit_data_o = wr_next[ELEM_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      buf_q <= '0;
    end else if (fire_i) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      dir_q <= we_eff_o;
      buf_q <= we_eff_o ? wr_next : {{DATA_W{1'b0}}, rd_base[BUF_W-1:DATA_W]};
    end
  end
endmodule

// File: rtl/opio_regs.sv
module opio_regs #(
  parameter int ELEM_W   = 163,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int WORDS    = 6,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int OFF_W   = $clog2(WORDS) + 1,
  localparam int BUF_W   = WORDS * DATA_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           full_we_i,
  input  logic [IDX_W-1:0]               full_idx_i,
  input  logic [ELEM_W-1:0]              full_data_i,
  input  logic                           word_we_i,
  input  logic [IDX_W-1:0]               word_idx_i,
  input  logic [OFF_W-1:0]               word_off_i,
  input  logic [DATA_W-1:0]              word_data_i,
  output logic [NUM_REGS-1:0][ELEM_W-1:0] regs_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [ELEM_W-1:0] q;
    logic [BUF_W-1:0]  ext;

    always_comb begin
      ext = BUF_W'(q);
      if (word_we_i && word_idx_i == IDX_W'(r))
        ext[int'(word_off_i) * DATA_W +: DATA_W] = word_data_i;
      if (full_we_i && full_idx_i == IDX_W'(r))
        ext = BUF_W'(full_data_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= ext[ELEM_W-1:0];
    end

    assign regs_o[r] = q;
  end
endmodule

// File: rtl/opio_top.sv
module opio_top
  import opio_pkg::*;
#(
  parameter int ELEM_W   = 163,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  localparam int WORDS   = words_of(ELEM_W, DATA_W),
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int OFF_W   = $clog2(WORDS) + 1,
  localparam int BUF_W   = WORDS * DATA_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic                         mode_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [OFF_W-1:0]             off_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic                         ack_o,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         err_o,
  output logic [NUM_REGS*ELEM_W-1:0]   opnd_o
);
  logic                           fire, ser_busy, ser_we, commit;
  logic [DATA_W-1:0]              ser_rdata, adr_rdata;
  logic [ELEM_W-1:0]              commit_data;
  logic [NUM_REGS-1:0][ELEM_W-1:0] regs;
  logic [IDX_W-1:0]               ser_idx_q, ser_idx;
  logic [DATA_W-1:0]              rdata_q;
  logic                           err_q;
  opio_mode_e                     mode_eff;
  logic                           off_ok, ser_fire, adr_fire;
  logic [BUF_W-1:0]               adr_ext;

  opio_hs u_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .ack_o  (ack_o),
    .fire_o (fire)
  );

  // an unfinished serial element locks mode, register and direction
  assign mode_eff = ser_busy ? MODE_SER : opio_mode_e'(mode_i);
  assign ser_idx  = ser_busy ? ser_idx_q : idx_i;
  assign ser_fire = fire & (mode_eff == MODE_SER);
  assign adr_fire = fire & (mode_eff == MODE_ADR);
  assign off_ok   = int'(off_i) < WORDS;

  opio_shift #(.ELEM_W(ELEM_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_shift (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fire_i        (ser_fire),
    .we_i          (we_i),
    .src_i         (regs[ser_idx]),
    .wdata_i       (wdata_i),
    .busy_o        (ser_busy),
    .we_eff_o      (ser_we),
    .rdata_o       (ser_rdata),
    .commit_o      (commit),
    .commit_data_o (commit_data)
  );

  opio_regs #(.ELEM_W(ELEM_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .WORDS(WORDS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .full_we_i   (commit),
    .full_idx_i  (ser_idx),
    .full_data_i (commit_data),
    .word_we_i   (adr_fire & we_i & off_ok),
    .word_idx_i  (idx_i),
    .word_off_i  (off_i),
    .word_data_i (wdata_i),
    .regs_o      (regs)
  );

  assign adr_ext   = BUF_W'(regs[idx_i]);
  assign adr_rdata = off_ok ? adr_ext[int'(off_i) * DATA_W +: DATA_W] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_idx_q <= '0;
      rdata_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      if (ser_fire) begin
        ser_idx_q <= ser_idx;
        if (!ser_we) rdata_q <= ser_rdata;
      end
      if (adr_fire) begin
        err_q <= ~off_ok;
        if (!we_i) rdata_q <= adr_rdata;
      end
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_out
    assign opnd_o[r*ELEM_W +: ELEM_W] = regs[r];
  end
endmodule

// File: rtl/opio_chk.sv
module opio_chk #(
  parameter int OPND_W = 652,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ack_o,
  input logic              err_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [OPND_W-1:0] opnd_o
);
  p_ack_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !$past(ack_o)) |-> $past(req_i));
  p_ack_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_o && $past(ack_o)) |-> !$past(req_i));
  p_ack_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_i) |=> ack_o);
  p_opnd_at_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && !$past(ack_o)) |-> $stable(opnd_o));
  p_err_at_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && !$past(ack_o)) |-> $stable(err_o));
  p_rdata_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(ack_o)) |-> $stable(rdata_o));
  always_comb begin
    if (!rst_ni) p_reset_idle_r1: assert (!ack_o && !err_o);
  end
endmodule

bind opio_top opio_chk #(.OPND_W(NUM_REGS*ELEM_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .ack_o   (ack_o),
  .err_o   (err_o),
  .rdata_o (rdata_o),
  .opnd_o  (opnd_o)
);

// File: tb/tb_opio_top.sv
module tb_opio_top;
  localparam int PERIOD = 10;
  localparam int EW = 163;
  localparam int DW = 32;
  localparam int NR = 4;
  localparam int NW = 6;
  localparam int BW = NW * DW;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0, mode = 0;
  logic [1:0] idx = 0;
  logic [3:0] off = 0;
  logic [DW-1:0] wdata = 0;
  logic ack, err;
  logic [DW-1:0] rdata;
  logic [NR*EW-1:0] opnd;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [EW-1:0] model [NR];

  always #(PERIOD/2) clk = ~clk;

  opio_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .mode_i(mode),
    .idx_i(idx), .off_i(off), .wdata_i(wdata),
    .ack_o(ack), .rdata_o(rdata), .err_o(err), .opnd_o(opnd)
  );

  task automatic chk(input bit ok, input string rq, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input logic [EW-1:0] v, input int k);
    logic [BW-1:0] e = BW'(v);
    return e[k*DW +: DW];
  endfunction

  function automatic logic [DW-1:0] pat(input int seed, input int k);
    return (k == NW-1) ? 32'hFFFF_FFFF : (32'h1357_9BDF * (seed + 1)) ^ (32'h0101_0101 * k);
  endfunction

  task automatic check_regs(input string rq);
    for (int r = 0; r < NR; r++)
      chk(opnd[r*EW +: EW] === model[r], rq, BW'(opnd[r*EW +: EW]), BW'(model[r]));
  endtask

  // one four-phase handshake; returns the read word and the cycles until ack
  task automatic xfer(input logic m, input logic w, input logic [1:0] ix, input logic [3:0] of,
                      input logic [DW-1:0] d, output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    mode = m; we = w; idx = ix; off = of; wdata = d; req = 1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!ack);
    rd = rdata;
    req = 0;
    do @(negedge clk); while (ack);
  endtask

  task automatic t_reset;
    chk(ack === 0, "R1 ack", BW'(ack), 0);
    chk(err === 0, "R1 err", BW'(err), 0);
    chk(rdata === 0, "R1 rdata", BW'(rdata), 0);
    check_regs("R1 regs");
  endtask

  task automatic t_handshake;
    logic [DW-1:0] rd; int lat;
    @(negedge clk);
    mode = 1; we = 0; idx = 0; off = 0; req = 1;
    @(negedge clk);
    chk(ack === 1, "R2 ack rise after one clock", BW'(ack), 1);
    @(negedge clk);
    chk(ack === 1, "R2 ack held while req high", BW'(ack), 1);
    req = 0;
    @(negedge clk);
    chk(ack === 0, "R2 ack falls after req low", BW'(ack), 0);
    xfer(1, 0, 0, 0, 0, rd, lat);
    chk(lat == 1, "R2 latency", BW'(lat), 1);
  endtask

  task automatic t_serial_write(input int ix, input int seed);
    logic [DW-1:0] rd; int lat; logic [BW-1:0] acc;
    for (int k = 0; k < NW; k++) begin
      xfer(0, 1, 2'(ix), 0, pat(seed, k), rd, lat);
      acc[k*DW +: DW] = pat(seed, k);
      if (k == NW-2) check_regs("R4 unchanged before last word");
    end
    model[ix] = acc[EW-1:0];
    check_regs("R3 serial write");
  endtask

  task automatic t_serial_read(input int ix);
    logic [DW-1:0] rd; int lat;
    for (int k = 0; k < NW; k++) begin
      xfer(0, 0, 2'(ix), 0, 0, rd, lat);
      chk(rd === word_of(model[ix], k), "R5 serial read word", BW'(rd), BW'(word_of(model[ix], k)));
    end
  endtask

  task automatic t_addr;
    logic [DW-1:0] rd; int lat; logic [BW-1:0] e;
    xfer(1, 1, 2, 3, 32'hDEAD_BEEF, rd, lat);
    e = BW'(model[2]); e[3*DW +: DW] = 32'hDEAD_BEEF; model[2] = e[EW-1:0];
    check_regs("R6 addressed write");
    xfer(1, 1, 0, 5, 32'hFFFF_FFFF, rd, lat);
    e = BW'(model[0]); e[5*DW +: DW] = 32'hFFFF_FFFF; model[0] = e[EW-1:0];
    check_regs("R6 padding dropped");
    xfer(1, 0, 2, 3, 0, rd, lat);
    chk(rd === 32'hDEAD_BEEF, "R7 addressed read", BW'(rd), BW'(32'hDEAD_BEEF));
    xfer(1, 0, 0, 5, 0, rd, lat);
    chk(rd === word_of(model[0], 5), "R7 padded read", BW'(rd), BW'(word_of(model[0], 5)));
  endtask

  task automatic t_bad_off;
    logic [DW-1:0] rd; int lat;
    xfer(1, 1, 1, 6, 32'h1234_5678, rd, lat);
    check_regs("R8 bad offset write ignored");
    chk(err === 1, "R8 err set", BW'(err), 1);
    xfer(1, 0, 1, 7, 0, rd, lat);
    chk(rd === 0, "R8 bad offset read zero", BW'(rd), 0);
    t_serial_read(1);
    chk(err === 1, "R8 serial keeps err", BW'(err), 1);
    xfer(1, 0, 1, 0, 0, rd, lat);
    chk(err === 0, "R8 valid clears err", BW'(err), 0);
  endtask

  task automatic t_lock;
    logic [DW-1:0] rd; int lat; logic [BW-1:0] acc;
    for (int k = 0; k < NW; k++) begin
      // after the first word, flip mode, index and direction
      if (k == 0) xfer(0, 1, 3, 0, pat(7, k), rd, lat);
      else        xfer(1, 0, 0, 2, pat(7, k), rd, lat);
      acc[k*DW +: DW] = pat(7, k);
    end
    model[3] = acc[EW-1:0];
    check_regs("R9 serial element locked");
  endtask

  task automatic t_reset_mid;
    logic [DW-1:0] rd; int lat;
    xfer(0, 1, 1, 0, 32'hAAAA_AAAA, rd, lat);
    xfer(0, 1, 1, 0, 32'hBBBB_BBBB, rd, lat);
    @(negedge clk); rst_ni = 0;
    @(negedge clk);
    chk(ack === 0 && err === 0, "R1 reset mid-run", BW'({ack, err}), 0);
    @(negedge clk); rst_ni = 1;
    for (int r = 0; r < NR; r++) model[r] = '0;
    check_regs("R10 reset clears");
    t_serial_write(1, 9);
    t_serial_read(1);
  endtask

  initial begin
    for (int r = 0; r < NR; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_handshake();
    t_serial_write(1, 1);
    t_serial_write(2, 2);
    t_serial_read(1);
    t_addr();
    t_bad_off();
    t_lock();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule